// File: doc/BRIEF.md
# Power-Bus Command Front-End

This block is the software-facing half of a master for a serial power-management bus. A processor reaches it over APB. For a write transfer, software fills up to four 32-bit write-data words and then posts a command word. For a read transfer, it posts the command word and later collects the bytes from the read-data words. The command word holds a start bit, an opcode, a byte count, a target slave ID and a 16-bit register address.

The block decodes the channel and register from the APB address and launches the command. It passes the request to a back-end serial engine over a valid/ready request and a single-cycle response. It then records the outcome in a status word kept for each slave. Read bytes go into read-data words that are also kept per slave. The serial wire protocol is not part of this block. Each channel owns its own back-end port, so channels run independently.

Top module: `spmi_cmd_frontend`

## Requirements
- R1: After reset every register reads as zero and no back-end request is raised.
- R2: The four write-data words sit at channel offsets 0x104, 0x108, 0x10C and 0x110. They read back what was last written while the channel is idle.
- R3: A write to the command word at offset 0x100 starts a transfer when bit 31 is set and the opcode is 10 or less. The fields are: opcode in bits 27:24, byte count minus one in bits 23:20, slave ID in bits 19:16, address in bits 15:0. It produces exactly one back-end request carrying those fields and the 16 write bytes, with byte k of the transfer at request bits 127-8k down to 120-8k. Byte 0 therefore comes from bits 31:24 of the word at 0x104.
- R4: Command bit 31 reads 1 while a transfer is pending and returns to 0 once it completes. Bits 30:0 read back the last accepted command.
- R5: Accepting a valid command clears done (bit 0) and fail (bit 2) in the target slave's status word at offset 0x200 + 0x20 × slave ID.
- R6: When the response arrives, done is set in that status word and fail is set equal to the response error flag.
- R7: Read opcodes are 2, 4 and 6. For these, response bytes land in the slave's read-data words at offsets 0x204 + 0x20 × slave ID + 4 × n. The first byte goes in bits 31:24 of word 0. Bytes at or beyond the count read as zero. Other opcodes leave the read-data words unchanged.
- R8: An opcode above 10 sets done and fail on the next cycle and raises no request.
- R9: Writes to the command or write-data words while a transfer is pending are ignored.
- R10: Channel n's registers repeat at n × 0x300. A command on one channel drives only that channel's back-end and touches only that channel's status.
- R11: A command word written with bit 31 clear starts nothing and changes no register.
- R12: A raised request keeps its valid and all its fields unchanged until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| be_req_valid | output | NUM_CH | Request valid per channel |
| be_req_ready | input | NUM_CH | Request ready per channel |
| be_req_op | output | 4*NUM_CH | Opcode per channel |
| be_req_sid | output | 4*NUM_CH | Slave ID per channel |
| be_req_addr | output | 16*NUM_CH | Register address per channel |
| be_req_len | output | 4*NUM_CH | Byte count minus one per channel |
| be_req_wdata | output | 128*NUM_CH | Write bytes, byte 0 at the top |
| be_rsp_valid | input | NUM_CH | Response strobe per channel |
| be_rsp_rdata | input | 128*NUM_CH | Read bytes, byte 0 at the top |
| be_rsp_err | input | NUM_CH | Response error flag |

## Verification
An APB command write takes effect at the edge of its access phase. A valid command raises the back-end request one cycle after that edge. An illegal opcode shows done and fail at that same edge. A response updates status, read data and the busy bit at the edge on which it is sampled. The bench drives everything on falling edges and samples the request fields there too. It reads registers only after a full APB access has crossed the edge that updates them, and it waits for the busy bit to clear before checking completion. The back-end model holds ready low for a set number of cycles and delays its response. This keeps the checks made while a transfer is pending inside that known window.

// File: rtl/spmi_fe_pkg.sv
package spmi_fe_pkg;
    localparam int DWORDS = 4;
    localparam int DBITS = 32 * DWORDS;
    localparam int NBYTES = DBITS / 8;
    localparam int WI_W = $clog2(DWORDS);
    localparam int NSLV = 16;
    localparam int SID_W = 4;
    localparam int CMD_OFS = 'h100;
    localparam int STAT_OFS = 'h200;
    localparam logic [3:0] OP_MAX = 4'd10;

    typedef enum logic [2:0] {K_NONE, K_CMD, K_WDAT, K_STAT, K_RDAT} kind_e;
    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

    function automatic logic op_reads(input logic [3:0] op);
        return (op == 4'd2) || (op == 4'd4) || (op == 4'd6);
    endfunction
endpackage

// File: rtl/spmi_fe_decode.sv
module spmi_fe_decode
    import spmi_fe_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 12,
    parameter int CH_STRIDE = 'h300,
    parameter int SLV_STRIDE = 'h20,
    parameter int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] paddr,
    output logic              hit,
    output logic [CH_W-1:0]   ch,
    output kind_e             kind,
    output logic [SID_W-1:0]  sid,
    output logic [WI_W-1:0]   widx
);
    int a, off, rel, w;

    always_comb begin
        hit  = 1'b0;
        ch   = '0;
        kind = K_NONE;
        sid  = '0;
        widx = '0;
        a    = int'(paddr);
        off  = 0;
        rel  = 0;
        w    = 0;
        for (int c = 0; c < NUM_CH; c++) begin
            off = a - c * CH_STRIDE;
            if (off >= CMD_OFS && off <= CMD_OFS + 4 * DWORDS) begin
                hit = 1'b1;
                ch  = CH_W'(c);
                if (off == CMD_OFS) begin
                    kind = K_CMD;
                end else begin
                    kind = K_WDAT;
                    widx = WI_W'((off - CMD_OFS - 4) / 4);
                end
            end else if (off >= STAT_OFS && off < STAT_OFS + NSLV * SLV_STRIDE) begin
                rel = off - STAT_OFS;
                w   = rel % SLV_STRIDE;
                if (w <= 4 * DWORDS) begin
                    hit = 1'b1;
                    ch  = CH_W'(c);
                    sid = SID_W'(rel / SLV_STRIDE);
                    if (w == 0) begin
                        kind = K_STAT;
                    end else begin
                        kind = K_RDAT;
                        widx = WI_W'((w - 4) / 4);
                    end
                end
            end
        end
        if (paddr[1:0] != 2'b00) begin
            hit  = 1'b0;
            kind = K_NONE;
        end
    end
endmodule

// File: rtl/spmi_fe_rd_pack.sv
module spmi_fe_rd_pack
    import spmi_fe_pkg::*;
(
    input  logic [3:0]       len_m1,
    input  logic [DBITS-1:0] raw,
    output logic [DBITS-1:0] packed_o
);
    logic [7:0]       sh;
    logic [DBITS-1:0] keep;

    // Bytes past the count sit at the low end of the vector; clear them.
    assign sh       = 8'((NBYTES - 1 - int'(len_m1)) * 8);
    assign keep     = {DBITS{1'b1}} << sh;
    assign packed_o = raw & keep;
endmodule

// File: rtl/spmi_fe_chan.sv
module spmi_fe_chan
    import spmi_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_wr,
    input  kind_e            acc_kind,
    input  logic [SID_W-1:0] acc_sid,
    input  logic [WI_W-1:0]  acc_idx,
    input  logic [31:0]      acc_wdata,
    output logic [31:0]      acc_rdata,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [3:0]       req_op,
    output logic [3:0]       req_sid,
    output logic [15:0]      req_addr,
    output logic [3:0]       req_len,
    output logic [DBITS-1:0] req_wdata,
    input  logic             rsp_valid,
    input  logic [DBITS-1:0] rsp_rdata,
    input  logic             rsp_err
);
    typedef struct packed {
        st_e                         st;
        logic [30:0]                 cmd;
        logic [DBITS-1:0]            wdat;
        logic [NSLV-1:0]             done;
        logic [NSLV-1:0]             fail;
        logic [NSLV-1:0][DBITS-1:0]  rdat;
    } chan_s;

    chan_s q, d;
    logic [3:0]       q_op, q_len;
    logic [SID_W-1:0] q_sid, new_sid;
    logic             start, bad_op;
    logic [DBITS-1:0] rsp_packed;

    assign q_op    = q.cmd[27:24];
    assign q_len   = q.cmd[23:20];
    assign q_sid   = q.cmd[19:16];
    assign new_sid = acc_wdata[19:16];

    spmi_fe_rd_pack u_pack (
        .len_m1   (q_len),
        .raw      (rsp_rdata),
        .packed_o (rsp_packed)
    );

    always_comb begin
        d      = q;
        start  = acc_wr && (acc_kind == K_CMD) && acc_wdata[31] && (q.st == S_IDLE);
        bad_op = acc_wdata[27:24] > OP_MAX;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.cmd           = acc_wdata[30:0];
                    d.done[new_sid] = 1'b0;
                    d.fail[new_sid] = 1'b0;
                    if (bad_op) begin
                        d.done[new_sid] = 1'b1;
                        d.fail[new_sid] = 1'b1;
                    end else begin
                        d.st = S_REQ;
                    end
                end
                if (acc_wr && acc_kind == K_WDAT)
                    d.wdat[DBITS-1-32*int'(acc_idx) -: 32] = acc_wdata;
            end
            S_REQ: if (req_ready) d.st = S_WAIT;
            S_WAIT: begin
                if (rsp_valid) begin
                    d.st          = S_IDLE;
                    d.done[q_sid] = 1'b1;
                    d.fail[q_sid] = rsp_err;
                    if (op_reads(q_op)) d.rdat[q_sid] = rsp_packed;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (acc_kind)
            K_CMD:   acc_rdata = {q.st != S_IDLE, q.cmd};
            K_WDAT:  acc_rdata = q.wdat[DBITS-1-32*int'(acc_idx) -: 32];
            K_STAT:  acc_rdata = {29'b0, q.fail[acc_sid], 1'b0, q.done[acc_sid]};
            K_RDAT:  acc_rdata = q.rdat[acc_sid][DBITS-1-32*int'(acc_idx) -: 32];
            default: acc_rdata = '0;
        endcase
    end

    assign req_valid = (q.st == S_REQ);
    assign req_op    = q_op;
    assign req_sid   = q_sid;
    assign req_addr  = q.cmd[15:0];
    assign req_len   = q_len;
    assign req_wdata = q.wdat;

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_op) && $stable(req_sid)
            && $stable(req_addr) && $stable(req_len) && $stable(req_wdata)));

    assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !bad_op) |=> (!q.done[$past(new_sid)] && !q.fail[$past(new_sid)] && req_valid));

    assert_bad_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && bad_op) |=> (!req_valid && q.done[$past(new_sid)] && q.fail[$past(new_sid)]));

    assert_rsp_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WAIT && rsp_valid) |=>
            (q.st == S_IDLE && q.done[$past(q_sid)] && (q.fail[$past(q_sid)] == $past(rsp_err))));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && q.st != S_IDLE) |=> ($stable(q.cmd) && $stable(q.wdat)));
endmodule

// File: rtl/spmi_cmd_frontend.sv
module spmi_cmd_frontend
    import spmi_fe_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    psel,
    input  logic                    penable,
    input  logic                    pwrite,
    input  logic [ADDR_W-1:0]       paddr,
    input  logic [31:0]             pwdata,
    output logic [31:0]             prdata,
    output logic                    pready,
    output logic [NUM_CH-1:0]       be_req_valid,
    input  logic [NUM_CH-1:0]       be_req_ready,
    output logic [NUM_CH*4-1:0]     be_req_op,
    output logic [NUM_CH*4-1:0]     be_req_sid,
    output logic [NUM_CH*16-1:0]    be_req_addr,
    output logic [NUM_CH*4-1:0]     be_req_len,
    output logic [NUM_CH*DBITS-1:0] be_req_wdata,
    input  logic [NUM_CH-1:0]       be_rsp_valid,
    input  logic [NUM_CH*DBITS-1:0] be_rsp_rdata,
    input  logic [NUM_CH-1:0]       be_rsp_err
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic             dec_hit;
    logic [CH_W-1:0]  dec_ch;
    kind_e            dec_kind;
    logic [SID_W-1:0] dec_sid;
    logic [WI_W-1:0]  dec_idx;
    logic             wr_acc;
    logic [31:0]      ch_rd [NUM_CH];

    spmi_fe_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
        .paddr (paddr),
        .hit   (dec_hit),
        .ch    (dec_ch),
        .kind  (dec_kind),
        .sid   (dec_sid),
        .widx  (dec_idx)
    );

    assign wr_acc = psel && penable && pwrite && dec_hit;
    assign pready = 1'b1;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic  sel;
        kind_e k_c;
        assign sel = dec_hit && (dec_ch == CH_W'(c));
        assign k_c = sel ? dec_kind : K_NONE;

        spmi_fe_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_wr    (wr_acc && sel),
            .acc_kind  (k_c),
            .acc_sid   (dec_sid),
            .acc_idx   (dec_idx),
            .acc_wdata (pwdata),
            .acc_rdata (ch_rd[c]),
            .req_valid (be_req_valid[c]),
            .req_ready (be_req_ready[c]),
            .req_op    (be_req_op[c*4 +: 4]),
            .req_sid   (be_req_sid[c*4 +: 4]),
            .req_addr  (be_req_addr[c*16 +: 16]),
            .req_len   (be_req_len[c*4 +: 4]),
            .req_wdata (be_req_wdata[c*DBITS +: DBITS]),
            .rsp_valid (be_rsp_valid[c]),
            .rsp_rdata (be_rsp_rdata[c*DBITS +: DBITS]),
            .rsp_err   (be_rsp_err[c])
        );
    end

    always_comb begin
        prdata = '0;
        for (int c = 0; c < NUM_CH; c++) prdata = prdata | ch_rd[c];
    end
endmodule

// File: tb/sim_spmi_cmd_frontend.sv
module sim_spmi_cmd_frontend;
    import spmi_fe_pkg::*;
    localparam int NCH = 2;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic psel, penable, pwrite, pready;
    logic [AW-1:0] paddr;
    logic [31:0] pwdata, prdata;
    logic [NCH-1:0] be_req_valid, be_req_ready, be_rsp_valid, be_rsp_err;
    logic [NCH*4-1:0] be_req_op, be_req_sid, be_req_len;
    logic [NCH*16-1:0] be_req_addr;
    logic [NCH*128-1:0] be_req_wdata, be_rsp_rdata;

    spmi_cmd_frontend #(.NUM_CH(NCH), .ADDR_W(AW)) u0 (.*);

    typedef struct packed {
        logic [3:0] op; logic [3:0] sid; logic [15:0] addr; logic [3:0] len; logic [127:0] wdat;
    } req_t;

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    req_t exp_q[NCH][$];
    logic [127:0] cfg_data [NCH];
    logic cfg_err [NCH];
    int cfg_stall [NCH], cfg_dly [NCH], seen [NCH];
    logic [31:0] wsh [NCH][4];

    task automatic check(string tag, logic [159:0] act, logic [159:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Back-end model and scoreboard monitor, one per channel
    for (genvar c = 0; c < NCH; c++) begin : g_be
        logic rdy, rv, er;
        logic [127:0] rd;
        assign be_req_ready[c] = rdy;
        assign be_rsp_valid[c] = rv;
        assign be_rsp_err[c] = er;
        assign be_rsp_rdata[c*128 +: 128] = rd;
        initial begin
            req_t snap, now_r;
            bit held;
            int head;
            rdy = 0; rv = 0; er = 0; rd = '0; head = 0; seen[c] = 0;
            forever begin
                @(negedge clk);
                if (be_req_valid[c] === 1'b1) begin
                    snap = {be_req_op[c*4 +: 4], be_req_sid[c*4 +: 4], be_req_addr[c*16 +: 16],
                            be_req_len[c*4 +: 4], be_req_wdata[c*128 +: 128]};
                    held = 1;
                    for (int s = 0; s < cfg_stall[c]; s++) begin
                        @(negedge clk);
                        now_r = {be_req_op[c*4 +: 4], be_req_sid[c*4 +: 4], be_req_addr[c*16 +: 16],
                                 be_req_len[c*4 +: 4], be_req_wdata[c*128 +: 128]};
                        if (be_req_valid[c] !== 1'b1 || now_r !== snap) held = 0;
                    end
                    check("R12 request held while stalled", 160'(held), 160'(1));
                    rdy = 1;
                    if (head >= exp_q[c].size()) begin
                        n_run++; n_fail++;
                        $display("FAIL R8 R9 R11 unexpected request ch%0d act=%0h exp=none", c, snap);
                    end else begin
                        check("R3 request fields", 160'(snap), 160'(exp_q[c][head]));
                    end
                    head++;
                    seen[c] = head;
                    @(negedge clk);
                    rdy = 0;
                    repeat (cfg_dly[c]) @(negedge clk);
                    rd = cfg_data[c]; er = cfg_err[c]; rv = 1;
                    @(negedge clk);
                    rv = 0;
                end
            end
        end
    end

    function automatic int cb(int ch); return ch * 'h300; endfunction
    function automatic int stat_a(int ch, int sid); return cb(ch) + 'h200 + 'h20 * sid; endfunction
    function automatic int rdat_a(int ch, int sid, int w); return stat_a(ch, sid) + 4 + 4 * w; endfunction

    function automatic logic [31:0] exp_word(logic [127:0] raw, int cnt, int w);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) begin
            int k = 4 * w + b;
            if (k < cnt) r[31-8*b -: 8] = raw[127-8*k -: 8];
        end
        return r;
    endfunction

    task automatic apb_wr(int a, logic [31:0] v);
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = AW'(a); pwdata = v;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(int a, output logic [31:0] v);
        @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = AW'(a);
        @(negedge clk); penable = 1;
        #1 v = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic rd_chk(string tag, int a, logic [31:0] exp);
        logic [31:0] v;
        apb_rd(a, v);
        check(tag, 160'(v), 160'(exp));
    endtask

    task automatic set_wdat(int ch, logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, logic [31:0] w3);
        wsh[ch][0] = w0; wsh[ch][1] = w1; wsh[ch][2] = w2; wsh[ch][3] = w3;
        for (int i = 0; i < 4; i++) apb_wr(cb(ch) + 'h104 + 4 * i, wsh[ch][i]);
    endtask

    task automatic issue(int ch, logic [3:0] op, int cnt, logic [3:0] sid, logic [15:0] addr, bit exp_req);
        req_t it;
        if (exp_req) begin
            it = {op, sid, addr, 4'(cnt - 1), wsh[ch][0], wsh[ch][1], wsh[ch][2], wsh[ch][3]};
            exp_q[ch].push_back(it);
        end
        apb_wr(cb(ch) + 'h100, {1'b1, 3'b0, op, 4'(cnt - 1), sid, addr});
    endtask

    task automatic wait_idle(int ch);
        logic [31:0] v;
        for (int i = 0; i < 100; i++) begin
            apb_rd(cb(ch) + 'h100, v);
            if (!v[31]) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] d0, d1;
        int prev;
        psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
        for (int c = 0; c < NCH; c++) begin
            cfg_data[c] = '0; cfg_err[c] = 0; cfg_stall[c] = 2; cfg_dly[c] = 3;
            for (int i = 0; i < 4; i++) wsh[c][i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        check("R1 no request after reset", 160'(be_req_valid), 160'(0));
        rd_chk("R1 cmd reset", cb(0) + 'h100, 32'h0);
        rd_chk("R1 wdata reset", cb(0) + 'h104, 32'h0);
        rd_chk("R1 status reset", stat_a(0, 3), 32'h0);
        rd_chk("R1 rdata reset", rdat_a(1, 0, 0), 32'h0);

        // R2: write-data words
        set_wdat(0, 32'hA1B2C3D4, 32'hE5F60718, 32'h292A3B4C, 32'h5D6E7F80);
        for (int i = 0; i < 4; i++) rd_chk("R2 wdata readback", cb(0) + 'h104 + 4 * i, wsh[0][i]);

        // R8: illegal opcode
        issue(0, 4'd12, 1, 4'd3, 16'h0, 0);
        rd_chk("R8 illegal opcode status", stat_a(0, 3), 32'h5);
        check("R8 no request for illegal opcode", 160'(seen[0]), 160'(0));

        // R3 R4 R5 R9: register write with a stalled back-end
        cfg_stall[0] = 3; cfg_dly[0] = 20;
        issue(0, 4'd1, 5, 4'd3, 16'h1234, 1);
        rd_chk("R4 busy bit and fields", cb(0) + 'h100, 32'h81431234);
        rd_chk("R5 status cleared on start", stat_a(0, 3), 32'h0);
        apb_wr(cb(0) + 'h104, 32'hDEADBEEF);
        issue(0, 4'd2, 2, 4'd5, 16'h0055, 0);
        wait_idle(0);
        check("R3 one request issued", 160'(seen[0]), 160'(1));
        rd_chk("R6 done without error", stat_a(0, 3), 32'h1);
        rd_chk("R4 busy clears, R9 command kept", cb(0) + 'h100, 32'h01431234);
        rd_chk("R9 wdata write ignored while busy", cb(0) + 'h104, 32'hA1B2C3D4);
        rd_chk("R9 ignored command left status", stat_a(0, 5), 32'h0);

        // R7 R6: reads with partial and full counts
        d0 = 128'h0102030405060708090A0B0C0D0E0F10;
        cfg_stall[0] = 0; cfg_dly[0] = 2; cfg_data[0] = d0; cfg_err[0] = 1;
        issue(0, 4'd2, 6, 4'd7, 16'h0020, 1);
        wait_idle(0);
        rd_chk("R6 fail follows error flag", stat_a(0, 7), 32'h5);
        for (int w = 0; w < 4; w++) rd_chk("R7 read packing count 6", rdat_a(0, 7, w), exp_word(d0, 6, w));

        d1 = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;
        cfg_data[0] = d1; cfg_err[0] = 0; cfg_stall[0] = 1;
        issue(0, 4'd6, 16, 4'd15, 16'hFFFF, 1);
        wait_idle(0);
        rd_chk("R6 done on long read", stat_a(0, 15), 32'h1);
        for (int w = 0; w < 4; w++) rd_chk("R7 read packing count 16", rdat_a(0, 15, w), exp_word(d1, 16, w));

        cfg_data[0] = d0;
        issue(0, 4'd4, 1, 4'd0, 16'h0100, 1);
        wait_idle(0);
        rd_chk("R7 single byte word0", rdat_a(0, 0, 0), 32'h01000000);
        rd_chk("R7 single byte word1", rdat_a(0, 0, 1), 32'h0);

        cfg_data[0] = d1;
        issue(0, 4'd3, 4, 4'd7, 16'h0099, 1);
        wait_idle(0);
        rd_chk("R7 write leaves rdata", rdat_a(0, 7, 0), 32'h01020304);

        issue(0, 4'd0, 1, 4'd1, 16'h0007, 1);
        wait_idle(0);
        rd_chk("R6 zero-write done", stat_a(0, 1), 32'h1);

        // R10: second channel
        set_wdat(1, 32'h11223344, 32'h55667788, 32'h99AABBCC, 32'hDDEEFF00);
        cfg_data[1] = d1; cfg_stall[1] = 2; cfg_dly[1] = 4;
        prev = seen[0];
        issue(1, 4'd6, 3, 4'd2, 16'hBEEF, 1);
        wait_idle(1);
        check("R10 request on channel 1", 160'(seen[1]), 160'(1));
        check("R10 channel 0 back-end idle", 160'(seen[0]), 160'(prev));
        rd_chk("R10 channel 1 status", stat_a(1, 2), 32'h1);
        rd_chk("R10 channel 1 rdata", rdat_a(1, 2, 0), exp_word(d1, 3, 0));
        rd_chk("R10 channel 0 status untouched", stat_a(0, 2), 32'h0);

        // R11: start bit clear
        prev = seen[0];
        apb_wr(cb(0) + 'h100, {1'b0, 3'b0, 4'd2, 4'd0, 4'd9, 16'h0});
        repeat (8) @(negedge clk);
        check("R11 no request without start bit", 160'(seen[0]), 160'(prev));
        rd_chk("R11 command unchanged", cb(0) + 'h100, 32'h00010007);
        rd_chk("R11 status unchanged", stat_a(0, 9), 32'h0);

        for (int c = 0; c < NCH; c++)
            check("R3 all expected requests seen", 160'(seen[c]), 160'(exp_q[c].size()));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule